// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Unit

This block gathers seven single-cycle event pulses from an audio codec and keeps each one in a sticky flag bit until the host clears it. The events are the sticky-clear event, jack change, short-circuit or mic-change, headphone ramp-up done, headphone ramp-down done, gain-up done and gain-down done. A mask register selects which flags may raise the single interrupt line. A two-bit form field shapes that line as an active-high or active-low level, or as an active-high or active-low one-cycle pulse.

The host reaches the unit through a simple 8-bit register port. A write has effect in the cycle in which the write strobe is high. Read data is combinational from the address. Three registers are decoded: the form control, the mask and the flags. Flags are cleared by writing ones to their positions. The pending state, meaning any flag that is not masked, is also shown in the top bit of the flag register read.

Top module: `codecIrqUnit`

## Requirements
- R1: After reset the flags read 0x00, the mask reads 0x7F, the form field reads 0 and the interrupt output is low.
- R2: An event pulse on bit i sets flag bit i at the next clock edge, and the flag stays set until it is cleared. The flag bits are: 6 sticky-clear, 5 jack, 4 short-circuit/mic-change, 3 ramp-up done, 2 ramp-down done, 1 gain-up done, 0 gain-down done. The flags are read at address 2, in bits 6:0.
- R3: A write to address 2 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0. Writing 0x7F clears all flags.
- R4: If a flag's event arrives in the same cycle as a clear of that bit, the flag stays set.
- R5: The mask is at address 1, in bits 6:0, using the flag bit positions. A set mask bit stops its flag from causing an interrupt. Bit 7 of the mask reads as 0.
- R6: Bit 7 of the address 2 read is 1 exactly when some flag is set and its mask bit is clear (pending).
- R7: The form field is at address 0, bits 7:6, and bits 5:0 read as 0. With form 0 the output equals pending (active-high level).
- R8: With form 1 the output is the inverse of pending (active-low level).
- R9: With form 2 the output is high for exactly the one cycle in which pending is 1 and was 0 in the cycle before. Otherwise it is low.
- R10: With form 3 the output is low for exactly that one cycle and high otherwise.
- R11: Address 3 reads 0x00, and a write to it changes no register. A write to the flag register never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 7 | Single-cycle event pulses, one per flag bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 form, 1 mask, 2 flags) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for regAddr |
| irqOut | output | 1 | Shaped interrupt output |

## Verification
Events are driven one bit at a time to show that each pulse lands in its own flag position. Partial and full clear patterns separate a bit-wise write-one-to-clear from a whole-register clear. An event arriving with a clear of the same bit checks that the event has priority. Mask changes made while flags are held show that masking gates only the output and not the latching. The pending edge is raised with the output in each of the four forms, which tells level from pulse and the polarity of each.

// File: rtl/codecIrqUnitPkg.sv
package codecIrqUnitPkg;
  localparam int FLAG_W = 7;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int FORM_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_FORM = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  typedef enum logic [FORM_W-1:0] {
    FORM_LVL_HI = 2'd0,
    FORM_LVL_LO = 2'd1,
    FORM_PLS_HI = 2'd2,
    FORM_PLS_LO = 2'd3
  } irqFormT;

  typedef enum logic [1:0] {
    RD_FORM,
    RD_MASK,
    RD_FLAG,
    RD_NONE
  } rdSelT;

  typedef struct packed {
    logic              wrForm;
    logic              wrMask;
    logic              clrFlags;
    rdSelT             rdSel;
    logic [DATA_W-1:0] data;
  } regStrobeT;
endpackage

// File: rtl/codecIrqCtrl.sv
module codecIrqCtrl
  import codecIrqUnitPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output regStrobeT     strb
);
  always_comb begin
    strb          = '0;
    strb.data     = regWrData;
    strb.wrForm   = regWrEn && (regAddr == ADDR_FORM);
    strb.wrMask   = regWrEn && (regAddr == ADDR_MASK);
    strb.clrFlags = regWrEn && (regAddr == ADDR_FLAG);
    case (regAddr)
      ADDR_FORM: strb.rdSel = RD_FORM;
      ADDR_MASK: strb.rdSel = RD_MASK;
      ADDR_FLAG: strb.rdSel = RD_FLAG;
      default:   strb.rdSel = RD_NONE;
    endcase
  end

  // R11
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrForm, strb.wrMask, strb.clrFlags}));

  // R11
  no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(strb.wrForm || strb.wrMask || strb.clrFlags));
endmodule

// File: rtl/codecIrqDatapath.sv
module codecIrqDatapath
  import codecIrqUnitPkg::*;
#(
  parameter int FW  = FLAG_W,
  parameter int DW  = DATA_W,
  parameter int FMW = FORM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] evtPulse,
  input  regStrobeT     strb,
  output logic [DW-1:0] regRdData,
  output logic          irqOut
);
  localparam int PAD_W = DW - FW;
  localparam int LOW_W = DW - FMW;

  logic [FW-1:0]  flagQ;
  logic [FW-1:0]  maskQ;
  irqFormT        formQ;
  logic           pending;
  logic           pendPrevQ;
  logic           pendRise;

  for (genvar i = 0; i < FW; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)
        flagQ[i] <= 1'b0;
      else if (evtPulse[i])
        flagQ[i] <= 1'b1;
      else if (strb.clrFlags && strb.data[i])
        flagQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '1;
      formQ     <= FORM_LVL_HI;
      pendPrevQ <= 1'b0;
    end else begin
      if (strb.wrMask) maskQ <= strb.data[FW-1:0];
      if (strb.wrForm) formQ <= irqFormT'(strb.data[DW-1 -: FMW]);
      pendPrevQ <= pending;
    end
  end

  assign pending  = |(flagQ & ~maskQ);
  assign pendRise = pending && !pendPrevQ;

  always_comb begin
    case (formQ)
      FORM_LVL_HI: irqOut = pending;
      FORM_LVL_LO: irqOut = !pending;
      FORM_PLS_HI: irqOut = pendRise;
      default:     irqOut = !pendRise;
    endcase
  end

  always_comb begin
    case (strb.rdSel)
      RD_FORM: regRdData = {formQ, {LOW_W{1'b0}}};
      RD_MASK: regRdData = {{PAD_W{1'b0}}, maskQ};
      RD_FLAG: regRdData = {pending, {(PAD_W-1){1'b0}}, flagQ};
      default: regRdData = '0;
    endcase
  end

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((flagQ & $past(evtPulse)) == $past(evtPulse)));

  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrFlags |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFlags |=> ((flagQ & $past(strb.data[FW-1:0] & ~evtPulse)) == '0));

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (formQ == FORM_LVL_HI && ((flagQ & ~maskQ) == '0)) |-> !irqOut);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (formQ == FORM_PLS_HI && irqOut) |=> !(formQ == FORM_PLS_HI && irqOut));
endmodule

// File: rtl/codecIrqUnit.sv
module codecIrqUnit
  import codecIrqUnitPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] evtPulse,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  regStrobeT strb;

  codecIrqCtrl #(.AW(ADDR_W), .DW(DATA_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  codecIrqDatapath #(.FW(FLAG_W), .DW(DATA_W), .FMW(FORM_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .evtPulse  (evtPulse),
    .strb      (strb),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/codecIrqUnit_test.sv
module codecIrqUnit_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] evtPulse = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;

  int errors = 0;
  int checks = 0;
  int mFlags = 0;
  int mMask = 'h7F;
  int mForm = 0;
  int mPrev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codecIrqUnit uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  function automatic int pend();
    return ((mFlags & ~mMask & 'h7F) != 0) ? 1 : 0;
  endfunction

  function automatic int expRd(input int a);
    case (a)
      0: return (mForm << 6);
      1: return mMask;
      2: return (pend() << 7) | mFlags;
      default: return 0;
    endcase
  endfunction

  function automatic int expIrq();
    int rise;
    rise = (pend() == 1 && mPrev == 0) ? 1 : 0;
    case (mForm)
      0: return pend();
      1: return 1 - pend();
      2: return rise;
      default: return 1 - rise;
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (int'(regRdData) != expRd(int'(regAddr))) begin
      errors++;
      $display("FAIL %s rdData addr=%0d got=%02h exp=%02h", tag, regAddr,
               regRdData, expRd(int'(regAddr)));
    end
    checks++;
    if (int'(irqOut) != expIrq()) begin
      errors++;
      $display("FAIL %s irqOut got=%0d exp=%0d", tag, irqOut, expIrq());
    end
  endtask

  task automatic cyc(input logic [6:0] e, input logic we, input logic [1:0] a,
                     input logic [7:0] d, input string tag);
    int oldPend;
    evtPulse = e; regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    oldPend = pend();
    if (we && a == 2) mFlags = mFlags & ~int'(d[6:0]);
    mFlags = mFlags | int'(e);
    if (we && a == 1) mMask = int'(d[6:0]);
    if (we && a == 0) mForm = int'(d[7:6]);
    mPrev = oldPend;
    #1;
    compare(tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(7'h0, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    rstN = 1'b1;
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1");
    // R2 each event bit lands in its own flag, masked so no interrupt
    for (int i = 0; i < 7; i++) begin
      cyc(7'(1 << i), 1'b0, 2'd2, 8'h00, "R2");
      rd(2'd2, "R2");
      cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R3");
    end
    // R2 sticky over several cycles
    cyc(7'h24, 1'b0, 2'd2, 8'h00, "R2");
    for (int i = 0; i < 4; i++) rd(2'd2, "R2");
    // R5 unmask all, then mask again; bit 7 of mask reads 0
    cyc(7'h0, 1'b1, 2'd1, 8'h00, "R5");
    rd(2'd2, "R6");
    cyc(7'h0, 1'b1, 2'd1, 8'hFF, "R5");
    rd(2'd1, "R5"); rd(2'd2, "R6");
    cyc(7'h0, 1'b1, 2'd1, 8'h5B, "R5");
    rd(2'd2, "R6");
    // R3 partial clear then full clear
    cyc(7'h0, 1'b1, 2'd2, 8'h04, "R3");
    rd(2'd2, "R3");
    cyc(7'h13, 1'b0, 2'd2, 8'h00, "R2");
    cyc(7'h0, 1'b1, 2'd2, 8'h01, "R3");
    rd(2'd2, "R3");
    cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R3");
    rd(2'd2, "R3");
    // R4 event and clear of the same bit in one cycle
    cyc(7'h08, 1'b0, 2'd2, 8'h00, "R4");
    cyc(7'h08, 1'b1, 2'd2, 8'h08, "R4");
    rd(2'd2, "R4");
    cyc(7'h40, 1'b1, 2'd2, 8'h48, "R4");
    rd(2'd2, "R4");
    cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R3");
    // R7 level high, unmasked bit 3
    cyc(7'h0, 1'b1, 2'd1, 8'h77, "R7");
    rd(2'd0, "R7");
    cyc(7'h08, 1'b0, 2'd2, 8'h00, "R7");
    rd(2'd2, "R7");
    // R8 active-low level
    cyc(7'h0, 1'b1, 2'd0, 8'h7F, "R8");
    rd(2'd0, "R8"); rd(2'd2, "R8");
    cyc(7'h0, 1'b1, 2'd2, 8'h08, "R8");
    rd(2'd2, "R8");
    // R9 active-high pulse
    cyc(7'h0, 1'b1, 2'd0, 8'h80, "R9");
    rd(2'd0, "R9");
    cyc(7'h08, 1'b0, 2'd2, 8'h00, "R9");
    rd(2'd2, "R9"); rd(2'd2, "R9");
    cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R9");
    rd(2'd2, "R9");
    cyc(7'h01, 1'b0, 2'd2, 8'h00, "R9");
    cyc(7'h0, 1'b1, 2'd1, 8'h7E, "R9");
    rd(2'd2, "R9");
    cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R9");
    // R10 active-low pulse
    cyc(7'h0, 1'b1, 2'd0, 8'hC0, "R10");
    cyc(7'h01, 1'b0, 2'd2, 8'h00, "R10");
    rd(2'd2, "R10"); rd(2'd2, "R10");
    // R11 unused address and no flag set by write
    cyc(7'h0, 1'b1, 2'd3, 8'hFF, "R11");
    rd(2'd3, "R11"); rd(2'd0, "R11"); rd(2'd1, "R11");
    cyc(7'h0, 1'b1, 2'd2, 8'h00, "R11");
    rd(2'd2, "R11");
    cyc(7'h0, 1'b1, 2'd2, 8'h7F, "R11");
    rd(2'd2, "R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule